// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block applies a single-step arithmetic, logic, shift or rotate operation to one or two operands of 8 or 16 bits. It keeps a 16-bit flags register in which every flag has a fixed bit position. Each accepted operation follows its own rules for each flag: the flag is computed, forced to a constant, or left at its previous value. Flags whose value the operation leaves undefined also keep their previous value. A datapath or sequencer drives an operation code, a size bit and the operands, and pulses `go`. One clock later the registered result and the registered flags show the effect of that operation.

The operation set is add, add with carry-in, subtract, subtract with borrow-in, compare, increment, decrement, negate, AND, OR, XOR, TEST, NOT, shift left, logical shift right, arithmetic shift right, rotate left and right (plain and through carry), all by one position, and a carry-to-byte operation. Compare and TEST compute flags only. They leave the result register as it was.

Top module: `alu16_flags`

## Requirements
- R1: A synchronous active-high `rst` sets `res_q` and `flags_q` to 0x0000.
- R2: Flag positions in `flags_q` are carry bit 0, parity bit 2, half-carry bit 4, zero bit 6, sign bit 7 and overflow bit 11. No operation changes any other bit, so after reset those bits read 0.
- R3: ADD (A+B), ADC (A+B+carry), SUB (A−B), SBB (A−B−carry) and NEG (0−A) write their result and update all six status flags. Carry is the carry or borrow out of the operand's top bit. Half-carry is the carry or borrow out of bit 3. Overflow is signed overflow. Zero is set for a zero result. Sign is the result's top bit. Parity is set when the low 8 result bits hold an even number of ones.
- R4: Compare sets the six status flags exactly as SUB would and does not change `res_q`.
- R5: INC (A+1) and DEC (A−1) write the result and update overflow, sign, zero, half-carry and parity. Carry keeps its previous value.
- R6: AND, OR, XOR and TEST clear carry and overflow, update sign, zero and parity, and keep half-carry. TEST is AND that does not change `res_q`.
- R7: NOT writes the bitwise inverse of A and changes no flag.
- R8: Shifts by one: SHL fills bit 0 with 0, SHR fills the top bit with 0, and SAR repeats the sign bit. For all three, carry receives the bit shifted out and sign, zero and parity follow the result. Overflow is top-bit-of-result XOR new carry for SHL, the original top bit for SHR, and 0 for SAR. Half-carry keeps its value.
- R9: Rotates by one change only carry and overflow. ROL/ROR move the departing bit into both the opposite end and carry. RCL/RCR move the old carry into the vacated end and the departing bit into carry. Overflow is top bit XOR new carry for left rotates, and XOR of the two top result bits for right rotates.
- R10: The carry-to-byte operation writes 0x00FF when carry is 1 and 0x0000 when carry is 0, and changes no flag.
- R11: With `byte_mode`=1 every operation uses only the low 8 bits of each operand. The upper result byte is 0, and sign, carry, overflow and zero are taken at bit 7 and over the low 8 bits.
- R12: Operation codes are ADD 0, ADC 1, SUB 2, SBB 3, CMP 4, INC 5, DEC 6, NEG 7, AND 8, OR 9, XOR 10, TEST 11, NOT 12, SHL 13, SHR 14, SAR 15, ROL 16, ROR 17, RCL 18, RCR 19, carry-to-byte 20. An operation takes effect at the clock edge where `go`=1, and is visible on the outputs after that edge. When `go`=0, or when the code is 21 to 31, result and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Write-enable: apply the operation this cycle |
| op_code | input | 5 | Operation select (encoding in R12) |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| opa | input | W (16) | First operand |
| opb | input | W (16) | Second operand |
| res_q | output | W (16) | Registered result |
| flags_q | output | 16 | Registered status flags |

## Verification
In one cycle, an operation both reads the flags register and replaces part of it. ADC, SBB, RCL, RCR and carry-to-byte consume the carry left by the previous operation while producing a new one, and partial-update operations must merge new flags with old ones. The bench provokes this with back-to-back random operations, so that each one inherits the flags of its predecessor. It mixes in directed carry-producing edge operands and size switches. A behavioural model, advanced on every clock and judged after each edge, checks the merged flags and the result.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int FLAG_W = 16;
  localparam int CF_B = 0;
  localparam int PF_B = 2;
  localparam int AF_B = 4;
  localparam int ZF_B = 6;
  localparam int SF_B = 7;
  localparam int OF_B = 11;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP  = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_NEG = 5'd7,
    OP_AND  = 5'd8,  OP_OR  = 5'd9,  OP_XOR = 5'd10, OP_TEST = 5'd11,
    OP_NOT  = 5'd12, OP_SHL = 5'd13, OP_SHR = 5'd14, OP_SAR = 5'd15,
    OP_ROL  = 5'd16, OP_ROR = 5'd17, OP_RCL = 5'd18, OP_RCR = 5'd19,
    OP_SALC = 5'd20
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_SHL, SH_SHR, SH_SAR, SH_ROL, SH_ROR, SH_RCL, SH_RCR
  } shift_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOT} logic_e;

  // Which flag-update rule an operation follows
  typedef enum logic [2:0] {
    FU_NONE, FU_ARITH, FU_ARITH_KEEPC, FU_LOGIC, FU_SHIFT, FU_ROT
  } flag_rule_e;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         byte_mode,
  input  logic         carry_in,
  input  logic         subtract,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         af,
  output logic         of
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{H{1'b0}}, {H{1'b1}}};

  logic [W-1:0] am, bm;
  logic [W:0]   raw;
  logic         sa, sb, sr;

  always_comb begin
    am = byte_mode ? (a & LOW_MASK) : a;
    bm = byte_mode ? (b & LOW_MASK) : b;
    if (subtract)
      raw = {1'b0, am} - {1'b0, bm} - {{W{1'b0}}, carry_in};
    else
      raw = {1'b0, am} + {1'b0, bm} + {{W{1'b0}}, carry_in};
    res = byte_mode ? (raw[W-1:0] & LOW_MASK) : raw[W-1:0];
    cf  = byte_mode ? raw[H] : raw[W];
    af  = am[4] ^ bm[4] ^ raw[4];
    sa  = byte_mode ? am[H-1]  : am[W-1];
    sb  = byte_mode ? bm[H-1]  : bm[W-1];
    sr  = byte_mode ? raw[H-1] : raw[W-1];
    of  = subtract ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic import alu16_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         byte_mode,
  input  logic_e       sel,
  output logic [W-1:0] res
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{H{1'b0}}, {H{1'b1}}};

  logic [W-1:0] raw;

  always_comb begin
    unique case (sel)
      LG_AND:  raw = a & b;
      LG_OR:   raw = a | b;
      LG_XOR:  raw = a ^ b;
      default: raw = ~a;
    endcase
    res = byte_mode ? (raw & LOW_MASK) : raw;
  end
endmodule

// File: rtl/alu16_shift1.sv
module alu16_shift1 import alu16_pkg::*; #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic         cf_in,
  input  shift_e       kind,
  output logic [N-1:0] r,
  output logic         cf,
  output logic         of
);
  always_comb begin
    unique case (kind)
      SH_SHL: begin r = {a[N-2:0], 1'b0};    cf = a[N-1]; end
      SH_SHR: begin r = {1'b0, a[N-1:1]};    cf = a[0];   end
      SH_SAR: begin r = {a[N-1], a[N-1:1]};  cf = a[0];   end
      SH_ROL: begin r = {a[N-2:0], a[N-1]};  cf = a[N-1]; end
      SH_ROR: begin r = {a[0], a[N-1:1]};    cf = a[0];   end
      SH_RCL: begin r = {a[N-2:0], cf_in};   cf = a[N-1]; end
      default: begin r = {cf_in, a[N-1:1]};  cf = a[0];   end
    endcase
    unique case (kind)
      SH_SHR:                  of = a[N-1];
      SH_SAR:                  of = 1'b0;
      SH_ROR, SH_RCR:          of = r[N-1] ^ r[N-2];
      default:                 of = r[N-1] ^ cf;
    endcase
  end
endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter import alu16_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic         byte_mode,
  input  logic         cf_in,
  input  shift_e       kind,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         of
);
  localparam int H = W / 2;

  logic [W-1:0] r_sz [2];
  logic         c_sz [2];
  logic         o_sz [2];

  // index 0: byte-width variant, index 1: full-width variant
  for (genvar g = 0; g < 2; g++) begin : g_size
    localparam int N = (g == 0) ? H : W;
    logic [N-1:0] r_n;
    alu16_shift1 #(.N(N)) u_sh (
      .a    (a[N-1:0]),
      .cf_in(cf_in),
      .kind (kind),
      .r    (r_n),
      .cf   (c_sz[g]),
      .of   (o_sz[g])
    );
    assign r_sz[g] = W'(r_n);
  end

  assign res = byte_mode ? r_sz[0] : r_sz[1];
  assign cf  = byte_mode ? c_sz[0] : c_sz[1];
  assign of  = byte_mode ? o_sz[0] : o_sz[1];
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags import alu16_pkg::*; #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [4:0]        op_code,
  input  logic              byte_mode,
  input  logic [W-1:0]      opa,
  input  logic [W-1:0]      opb,
  output logic [W-1:0]      res_q,
  output logic [FLAG_W-1:0] flags_q
);
  localparam int H = W / 2;

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  // operand steering
  logic [W-1:0] ar_a, ar_b, ar_res, lg_res, sh_res, r_nxt;
  logic         ar_cin, ar_sub, ar_cf, ar_af, ar_of, sh_cf, sh_of;
  logic         wr_res;
  logic_e       lg_sel;
  shift_e       sh_kind;
  flag_rule_e   rule;
  logic [W-1:0] cand;
  logic [FLAG_W-1:0] f_nxt;

  always_comb begin
    ar_a    = opa;
    ar_b    = opb;
    ar_cin  = 1'b0;
    ar_sub  = 1'b0;
    lg_sel  = LG_AND;
    sh_kind = SH_SHL;
    case (op)
      OP_ADC:         ar_cin = flags_q[CF_B];
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SBB: begin ar_sub = 1'b1; ar_cin = flags_q[CF_B]; end
      OP_INC:         ar_b = W'(1);
      OP_DEC: begin ar_b = W'(1); ar_sub = 1'b1; end
      OP_NEG: begin ar_a = '0; ar_b = opa; ar_sub = 1'b1; end
      OP_OR:          lg_sel = LG_OR;
      OP_XOR:         lg_sel = LG_XOR;
      OP_NOT:         lg_sel = LG_NOT;
      OP_SHR:         sh_kind = SH_SHR;
      OP_SAR:         sh_kind = SH_SAR;
      OP_ROL:         sh_kind = SH_ROL;
      OP_ROR:         sh_kind = SH_ROR;
      OP_RCL:         sh_kind = SH_RCL;
      OP_RCR:         sh_kind = SH_RCR;
      default: ;
    endcase
  end

  alu16_arith #(.W(W)) u_arith (
    .a(ar_a), .b(ar_b), .byte_mode(byte_mode), .carry_in(ar_cin),
    .subtract(ar_sub), .res(ar_res), .cf(ar_cf), .af(ar_af), .of(ar_of)
  );

  alu16_logic #(.W(W)) u_logic (
    .a(opa), .b(opb), .byte_mode(byte_mode), .sel(lg_sel), .res(lg_res)
  );

  alu16_shifter #(.W(W)) u_shift (
    .a(opa), .byte_mode(byte_mode), .cf_in(flags_q[CF_B]), .kind(sh_kind),
    .res(sh_res), .cf(sh_cf), .of(sh_of)
  );

  // result selection and flag rule per operation
  always_comb begin
    rule   = FU_NONE;
    wr_res = 1'b0;
    cand   = ar_res;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG:
        begin rule = FU_ARITH; wr_res = 1'b1; end
      OP_CMP:  rule = FU_ARITH;
      OP_INC, OP_DEC:
        begin rule = FU_ARITH_KEEPC; wr_res = 1'b1; end
      OP_AND, OP_OR, OP_XOR:
        begin rule = FU_LOGIC; wr_res = 1'b1; cand = lg_res; end
      OP_TEST: begin rule = FU_LOGIC; cand = lg_res; end
      OP_NOT:  begin wr_res = 1'b1; cand = lg_res; end
      OP_SHL, OP_SHR, OP_SAR:
        begin rule = FU_SHIFT; wr_res = 1'b1; cand = sh_res; end
      OP_ROL, OP_ROR, OP_RCL, OP_RCR:
        begin rule = FU_ROT; wr_res = 1'b1; cand = sh_res; end
      OP_SALC: begin
        wr_res = 1'b1;
        cand   = flags_q[CF_B] ? W'({H{1'b1}}) : '0;
      end
      default: ;
    endcase
  end

  function automatic logic [2:0] sign_zero_par(logic [W-1:0] v, logic bm);
    logic s, z, p;
    s = bm ? v[H-1] : v[W-1];
    z = bm ? (v[H-1:0] == '0) : (v == '0);
    p = ~^v[7:0];
    return {s, z, p};
  endfunction

  always_comb begin
    logic [2:0] szp;
    szp   = sign_zero_par(cand, byte_mode);
    f_nxt = flags_q;
    r_nxt = wr_res ? cand : res_q;
    case (rule)
      FU_ARITH, FU_ARITH_KEEPC: begin
        {f_nxt[SF_B], f_nxt[ZF_B], f_nxt[PF_B]} = szp;
        f_nxt[AF_B] = ar_af;
        f_nxt[OF_B] = ar_of;
        if (rule == FU_ARITH) f_nxt[CF_B] = ar_cf;
      end
      FU_LOGIC: begin
        {f_nxt[SF_B], f_nxt[ZF_B], f_nxt[PF_B]} = szp;
        f_nxt[OF_B] = 1'b0;
        f_nxt[CF_B] = 1'b0;
      end
      FU_SHIFT: begin
        {f_nxt[SF_B], f_nxt[ZF_B], f_nxt[PF_B]} = szp;
        f_nxt[OF_B] = sh_of;
        f_nxt[CF_B] = sh_cf;
      end
      FU_ROT: begin
        f_nxt[OF_B] = sh_of;
        f_nxt[CF_B] = sh_cf;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (go) begin
      res_q   <= r_nxt;
      flags_q <= f_nxt;
    end
  end
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk import alu16_pkg::*; #(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              go,
  input logic [4:0]        op_code,
  input logic [W-1:0]      res_q,
  input logic [FLAG_W-1:0] flags_q
);
  localparam logic [FLAG_W-1:0] STATUS_MASK = 16'h08D5;
  localparam logic [FLAG_W-1:0] OC_MASK     = 16'h0801;
  localparam int H = W / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (res_q == '0) && (flags_q == '0)); // R1

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~STATUS_MASK) == '0); // R2

  AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
    go && (op_code == 5'd4 || op_code == 5'd11) |=> $stable(res_q)); // R4

  AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    go && (op_code == 5'd5 || op_code == 5'd6) |=> $stable(flags_q[CF_B])); // R5

  AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (rst)
    go && (op_code >= 5'd8 && op_code <= 5'd11) |=> !flags_q[CF_B] && !flags_q[OF_B]); // R6

  AST_NOT_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    go && (op_code == 5'd12) |=> $stable(flags_q)); // R7

  AST_ROT_ONLY_CO: assert property (@(posedge clk) disable iff (rst)
    go && (op_code >= 5'd16 && op_code <= 5'd19)
    |=> (flags_q & ~OC_MASK) == ($past(flags_q) & ~OC_MASK)); // R9

  AST_SALC_VALUE: assert property (@(posedge clk) disable iff (rst)
    go && (op_code == 5'd20)
    |=> $stable(flags_q) && (res_q == ($past(flags_q[CF_B]) ? W'({H{1'b1}}) : '0))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!go || op_code > 5'd20) |=> $stable(flags_q) && $stable(res_q)); // R12
endmodule

bind alu16_flags alu16_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .op_code(op_code),
  .res_q(res_q), .flags_q(flags_q)
);

// File: tb/tb_alu16_flags.sv
`timescale 1ns/1ps
module tb_alu16_flags;
  localparam int W = 16;
  localparam real CLK_NS = 20.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [4:0] op_code = '0;
  logic byte_mode = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] res_q;
  logic [15:0] flags_q;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] exp_res = '0;
  logic [15:0] exp_fl = '0;

  always #(CLK_NS/2) clk = ~clk;

  alu16_flags #(.W(W)) dut (
    .clk(clk), .rst(rst), .go(go), .op_code(op_code), .byte_mode(byte_mode),
    .opa(opa), .opb(opb), .res_q(res_q), .flags_q(flags_q)
  );

  function automatic string req_tag(int op, bit bm, bit g);
    string t;
    if (!g || op > 20) return "R12";
    case (op)
      0, 1, 2, 3, 7: t = "R3";
      4:             t = "R4";
      5, 6:          t = "R5";
      8, 9, 10, 11:  t = "R6";
      12:            t = "R7";
      13, 14, 15:    t = "R8";
      16, 17, 18, 19: t = "R9";
      default:       t = "R10";
    endcase
    if (bm) t = {t, "/R11"};
    return t;
  endfunction

  // behavioural reference: integer arithmetic per operation
  task automatic model(int op, bit bm, int a, int b);
    int n = bm ? 8 : 16;
    int mask = (1 << n) - 1;
    int sgn = 1 << (n - 1);
    int x = a & mask;
    int y = b & mask;
    int r = 0;
    int t;
    bit c = exp_fl[0], p = exp_fl[2], h = exp_fl[4];
    bit z = exp_fl[6], s = exp_fl[7], o = exp_fl[11];
    bit wr = 0, szp = 0;
    case (op)
      0, 1: begin
        t = x + y + ((op == 1) ? int'(c) : 0);
        r = t & mask; c = ((t >> n) & 1) != 0;
        h = (((x ^ y ^ r) >> 4) & 1) != 0;
        o = ((x ^ r) & (y ^ r) & sgn) != 0; szp = 1; wr = 1;
      end
      2, 3, 4: begin
        t = x - y - ((op == 3) ? int'(c) : 0);
        r = t & mask; c = t < 0;
        h = (((x ^ y ^ r) >> 4) & 1) != 0;
        o = ((x ^ y) & (x ^ r) & sgn) != 0; szp = 1; wr = (op != 4);
      end
      5: begin r = (x + 1) & mask; h = (((x ^ 1 ^ r) >> 4) & 1) != 0;
               o = (r == sgn); szp = 1; wr = 1; end
      6: begin r = (x - 1) & mask; h = (((x ^ 1 ^ r) >> 4) & 1) != 0;
               o = (x == sgn); szp = 1; wr = 1; end
      7: begin r = (0 - x) & mask; c = (x != 0); h = (((x ^ r) >> 4) & 1) != 0;
               o = (x == sgn); szp = 1; wr = 1; end
      8, 9, 10, 11: begin
        r = (op == 9) ? (x | y) : (op == 10) ? (x ^ y) : (x & y);
        c = 0; o = 0; szp = 1; wr = (op != 11);
      end
      12: begin r = (~x) & mask; wr = 1; end
      13: begin c = ((x >> (n-1)) & 1) != 0; r = (x << 1) & mask;
                o = (((r >> (n-1)) & 1) != 0) != c; szp = 1; wr = 1; end
      14: begin c = (x & 1) != 0; r = x >> 1; o = ((x >> (n-1)) & 1) != 0;
                szp = 1; wr = 1; end
      15: begin c = (x & 1) != 0; r = (x >> 1) | (x & sgn); o = 0;
                szp = 1; wr = 1; end
      16, 18: begin
        t = (op == 16) ? ((x >> (n-1)) & 1) : int'(c);
        c = ((x >> (n-1)) & 1) != 0;
        r = ((x << 1) & mask) | t;
        o = (((r >> (n-1)) & 1) != 0) != c; wr = 1;
      end
      17, 19: begin
        t = (op == 17) ? (x & 1) : int'(c);
        c = (x & 1) != 0;
        r = (x >> 1) | ((t != 0) ? sgn : 0);
        o = (((r >> (n-1)) ^ (r >> (n-2))) & 1) != 0; wr = 1;
      end
      20: begin r = c ? 255 : 0; wr = 1; end
      default: ;
    endcase
    if (szp) begin
      z = (r == 0);
      s = (r & sgn) != 0;
      p = ($countones(r & 255) % 2) == 0;
    end
    if (op <= 20) begin
      exp_fl = 16'h0;
      exp_fl[0] = c; exp_fl[2] = p; exp_fl[4] = h;
      exp_fl[6] = z; exp_fl[7] = s; exp_fl[11] = o;
      if (wr) exp_res = r[15:0];
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(int op, bit bm, int a, int b, bit g);
    op_code = op[4:0]; byte_mode = bm; opa = a[15:0]; opb = b[15:0]; go = g;
    if (g) model(op, bm, a, b);
    @(negedge clk);
    total++;
    if (res_q !== exp_res || flags_q !== exp_fl) begin
      bad++;
      $display("FAIL %s op=%0d byte=%0d a=%h b=%h: res=%h exp=%h flags=%h exp=%h",
               req_tag(op, bm, g), op, bm, a[15:0], b[15:0],
               res_q, exp_res, flags_q, exp_fl);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      bad++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;  // R1 reset state
    if (res_q !== 16'h0 || flags_q !== 16'h0) begin
      bad++;
      $display("FAIL R1 reset: res=%h exp=0000 flags=%h exp=0000", res_q, flags_q);
    end

    // R3 carry, zero, half-carry from word wrap
    step(0, 0, 16'hFFFF, 16'h0001, 1);
    step(1, 0, 16'h1234, 16'h0001, 1);      // ADC consumes carry
    step(0, 0, 16'h7FFF, 16'h0001, 1);      // R3 signed overflow
    step(2, 0, 16'h0000, 16'h0001, 1);      // R3 borrow
    step(3, 0, 16'h0010, 16'h0001, 1);      // SBB consumes borrow
    step(7, 0, 16'h8000, 16'h0000, 1);      // NEG overflow corner
    step(7, 0, 16'h0000, 16'h0000, 1);      // NEG of zero, no carry
    step(4, 0, 16'h5555, 16'h5555, 1);      // R4 equal compare
    step(2, 0, 16'h0000, 16'h0001, 1);      // set carry
    step(5, 0, 16'hFFFF, 16'h0000, 1);      // R5 INC wraps, carry kept
    step(6, 0, 16'h8000, 16'h0000, 1);      // R5 DEC overflow
    step(8, 0, 16'hF0F0, 16'h0FF0, 1);      // R6 AND
    step(11, 0, 16'hFFFF, 16'h0000, 1);     // R6 TEST no write
    step(12, 0, 16'h00FF, 16'h0000, 1);     // R7 NOT
    step(13, 0, 16'hC001, 16'h0000, 1);     // R8 SHL
    step(14, 0, 16'h8001, 16'h0000, 1);     // R8 SHR
    step(15, 0, 16'h8001, 16'h0000, 1);     // R8 SAR
    step(20, 0, 16'h0000, 16'h0000, 1);     // R10 carry set
    step(16, 0, 16'h4000, 16'h0000, 1);     // R9 ROL
    step(17, 0, 16'h0001, 16'h0000, 1);     // R9 ROR
    step(18, 0, 16'h8000, 16'h0000, 1);     // R9 RCL
    step(19, 0, 16'h0001, 16'h0000, 1);     // R9 RCR
    step(2, 0, 16'h0005, 16'h0001, 1);      // clear carry
    step(20, 0, 16'hABCD, 16'h0000, 1);     // R10 carry clear
    step(0, 1, 16'hAA7F, 16'h5501, 1);      // R11 byte overflow
    step(0, 1, 16'h12FF, 16'h3401, 1);      // R11 byte carry/zero
    step(13, 1, 16'hFF80, 16'h0000, 1);     // R11 byte shift
    step(19, 1, 16'h0001, 16'h0000, 1);     // R11 byte rotate through carry
    step(0, 0, 16'h1111, 16'h2222, 0);      // R12 go low
    step(25, 0, 16'h1111, 16'h2222, 1);     // R12 undefined code

    for (int i = 0; i < 1500; i++) begin
      int op = $urandom_range(0, 23);
      int a = $urandom_range(0, 65535);
      int b = $urandom_range(0, 65535);
      int pick = $urandom_range(0, 7);
      if (pick == 0) a = 16'h8000;
      if (pick == 1) a = 16'h7FFF;
      if (pick == 2) b = a;
      if (pick == 3) a = 16'h00FF;
      step(op, $urandom_range(0, 1) == 1, a, b, $urandom_range(0, 9) != 0);
    end

    total++;  // R2 spare bits stay clear
    if ((flags_q & ~16'h08D5) !== 16'h0) begin
      bad++;
      $display("FAIL R2 spare bits: flags=%h exp spare=0000", flags_q);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule